// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is an on-chip word memory with a pipelined synchronous command interface in which data always moves one clock after its command. A read's data appears combinationally (flow-through) in the cycle after the read is accepted. A write's data is sampled at the edge after the write is accepted. Reads and writes can therefore alternate on every clock with no idle cycles on the data path.

Each enabled rising edge does one of four things. It loads a new address with a read or write command. It steps a two-bit burst counter for the burst already running. It deselects the block. Or it does nothing. Words are 36 bits, made of four 9-bit byte lanes, each with its own active-low write enable. A global active-low clock enable freezes the block completely. A static order input chooses a linear or an interleaved burst sequence. The pad is represented by separate data-in, data-out and drive-enable ports.

Top module: `zbt_sram_core`

## Requirements
- R1: An edge with cen_n=0, adv_ld=0, sel_a_n=0, sel_b_n=0 and sel_c=1 loads addr and the command type (rw=1 read, rw=0 write) and starts a new burst at that address.
- R2: In the cycle after an accepted read beat, with oe_n=0, dout_en is 1 and dout equals the stored word at the beat address (flow-through, no output register). rw and bw_n are ignored for read beats.
- R3: For an accepted write beat, din is sampled at the next enabled edge. Byte lane i (bits 9i+8..9i) is written only when bw_n[i], sampled with the beat's command, is 0. All other lanes keep their old value. dout_en is 0 during write data cycles.
- R4: An edge with adv_ld=1 during a burst ignores addr and issues the next beat. With burst_ilv=0 the beat k address has low two bits equal to (base+k) mod 4, the upper bits are unchanged, and the burst wraps after four beats.
- R5: With burst_ilv=1 the low two bits of beat k are base XOR k, and the upper bits are unchanged.
- R6: A burst continuation keeps the read/write type of its load and ignores rw. During a burst write, bw_n is sampled afresh on every beat.
- R7: adv_ld=0 on an edge where any chip select is false ends the burst, and dout_en is 0 in the following cycle. Later edges with adv_ld=1 issue nothing, so dout_en stays 0.
- R8: An edge with cen_n=1 is ignored entirely. Outputs and state are held, and no command, write data or array write takes effect. A write whose data cycle is stalled completes at the next enabled edge, using din from that edge.
- R9: A read loaded in the cycle directly after a write to the same address returns the newly written bytes. A write may directly follow a read.
- R10: oe_n=1 forces dout_en to 0 combinationally.
- R11: After reset, dout_en is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock enable; high freezes the block |
| adv_ld | input | 1 | 0 loads a command, 1 continues the burst |
| rw | input | 1 | Command type on load: 1 read, 0 write |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| addr | input | AW (8) | Word address on load cycles |
| bw_n | input | 4 | Active-low byte-lane write enables |
| din | input | 36 | Write data, sampled one edge after its beat |
| burst_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | 36 | Flow-through read data (zero when not driven) |
| dout_en | output | 1 | Bus drive enable |

## Verification
The hardest situations to reach are a write whose data cycle is frozen by the clock enable, and a burst write whose byte enables change from beat to beat, because both need the command and data phases offset in a specific way. The stimulus gets there with directed sequences. One loads a write, stalls the next edge while presenting wrong data, and then reads the same address back. The other runs a linear burst write in which one beat masks every lane and the next writes a single lane. It then reads both locations, and an untouched neighbour, to confirm exactly which bytes changed.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int unsigned BURST_CW = 2;

    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } burst_order_e;

    // Low address bits of beat k for a given starting value.
    function automatic logic [BURST_CW-1:0] beat_low(
        input logic [BURST_CW-1:0] start,
        input logic [BURST_CW-1:0] k,
        input burst_order_e        order
    );
        if (order == ORDER_INTERLEAVE) begin
            return start ^ k;
        end
        return start + k;
    endfunction

endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq
    import zbt_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_en,
    input  logic          load,
    input  logic          desel,
    input  logic          step,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_wr,
    input  logic          ilv,
    output logic [AW-1:0] step_addr,
    output logic          step_wr,
    output logic          busy
);

    localparam int unsigned CW = BURST_CW;

    typedef struct packed {
        logic          on;
        logic          wr;
        logic [AW-1:0] base;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [CW-1:0] cnt_next;
    burst_order_e  order;

    assign order    = burst_order_e'(ilv);
    assign cnt_next = seq_q.cnt + CW'(1);

    always_comb begin
        seq_d = seq_q;
        if (adv_en) begin
            if (load) begin
                seq_d.on   = 1'b1;
                seq_d.wr   = ld_wr;
                seq_d.base = ld_addr;
                seq_d.cnt  = '0;
            end else if (desel) begin
                seq_d.on  = 1'b0;
                seq_d.cnt = '0;
            end else if (step && seq_q.on) begin
                seq_d.cnt = cnt_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign step_addr = {seq_q.base[AW-1:CW], beat_low(seq_q.base[CW-1:0], cnt_next, order)};
    assign step_wr   = seq_q.wr;
    assign busy      = seq_q.on;

endmodule

// File: rtl/zbt_byte_array.sv
module zbt_byte_array #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned AW     = 8,
    parameter int unsigned NBYTES = 4,
    parameter int unsigned BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [NBYTES-1:0]        lane_en,
    input  logic [AW-1:0]            addr,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic [NBYTES*BYTE_W-1:0] rdata
);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) begin
                cells[addr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = cells[addr];
    end

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
    import zbt_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned NBYTES = 4,
    parameter int unsigned BYTE_W = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cen_n,
    input  logic                          adv_ld,
    input  logic                          rw,
    input  logic                          sel_a_n,
    input  logic                          sel_b_n,
    input  logic                          sel_c,
    input  logic [$clog2(DEPTH)-1:0]      addr,
    input  logic [NBYTES-1:0]             bw_n,
    input  logic [NBYTES*BYTE_W-1:0]      din,
    input  logic                          burst_ilv,
    input  logic                          oe_n,
    output logic [NBYTES*BYTE_W-1:0]      dout,
    output logic                          dout_en
);

    localparam int unsigned AW     = $clog2(DEPTH);
    localparam int unsigned WORD_W = NBYTES * BYTE_W;

    // Beat issued at the last enabled edge; its data moves in this cycle.
    typedef struct packed {
        logic              act;
        logic              wr;
        logic [AW-1:0]     addr;
        logic [NBYTES-1:0] bwn;
    } beat_t;

    beat_t beat_d, beat_q;

    logic          adv_en;
    logic          selected;
    logic          do_load;
    logic          do_desel;
    logic [AW-1:0] step_addr;
    logic          step_wr;
    logic          burst_on;
    logic          array_we;
    logic [WORD_W-1:0] rd_word;

    // Plain views of the beat register for the bound checker.
    logic          beat_act;
    logic          beat_wr;
    logic [AW-1:0] beat_addr;

    assign adv_en   = !cen_n;
    assign selected = !sel_a_n && !sel_b_n && sel_c;
    assign do_load  = !adv_ld && selected;
    assign do_desel = !adv_ld && !selected;

    zbt_burst_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv_en    (adv_en),
        .load      (do_load),
        .desel     (do_desel),
        .step      (adv_ld),
        .ld_addr   (addr),
        .ld_wr     (!rw),
        .ilv       (burst_ilv),
        .step_addr (step_addr),
        .step_wr   (step_wr),
        .busy      (burst_on)
    );

    always_comb begin
        beat_d = beat_q;
        if (adv_en) begin
            if (do_load) begin
                beat_d.act  = 1'b1;
                beat_d.wr   = !rw;
                beat_d.addr = addr;
                beat_d.bwn  = bw_n;
            end else if (do_desel) begin
                beat_d.act = 1'b0;
            end else if (burst_on) begin
                beat_d.act  = 1'b1;
                beat_d.wr   = step_wr;
                beat_d.addr = step_addr;
                beat_d.bwn  = bw_n;
            end else begin
                beat_d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    // Late write: the staged beat commits at the next enabled edge with din.
    assign array_we = adv_en && beat_q.act && beat_q.wr;

    zbt_byte_array #(
        .DEPTH  (DEPTH),
        .AW     (AW),
        .NBYTES (NBYTES),
        .BYTE_W (BYTE_W)
    ) u_array (
        .clk     (clk),
        .we      (array_we),
        .lane_en (~beat_q.bwn),
        .addr    (beat_q.addr),
        .wdata   (din),
        .rdata   (rd_word)
    );

    assign dout_en = beat_q.act && !beat_q.wr && !oe_n;
    assign dout    = dout_en ? rd_word : '0;

    assign beat_act  = beat_q.act;
    assign beat_wr   = beat_q.wr;
    assign beat_addr = beat_q.addr;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cen_n,
    input logic          adv_ld,
    input logic          rw,
    input logic          sel_a_n,
    input logic          sel_b_n,
    input logic          sel_c,
    input logic [AW-1:0] addr,
    input logic          oe_n,
    input logic          dout_en,
    input logic          beat_act,
    input logic          beat_wr,
    input logic [AW-1:0] beat_addr,
    input logic          burst_on
);

    logic chip_sel;
    assign chip_sel = !sel_a_n && !sel_b_n && sel_c;

    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && chip_sel) |=>
            (beat_act && burst_on && beat_addr == $past(addr) && beat_wr == !$past(rw)));

    a_r3_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_act && beat_wr) |-> !dout_en);

    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && burst_on) |=>
            (beat_addr[AW-1:2] == $past(beat_addr[AW-1:2])));

    a_r6_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && burst_on) |=> (beat_act && beat_wr == $past(beat_wr)));

    a_r7_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && !chip_sel) |=> (!dout_en && !burst_on));

    a_r7_idle_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && !burst_on) |=> !dout_en);

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(beat_act) && $stable(beat_addr) && $stable(beat_wr) && $stable(burst_on)));

    a_r10_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

endmodule

bind zbt_sram_core zbt_sram_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cen_n     (cen_n),
    .adv_ld    (adv_ld),
    .rw        (rw),
    .sel_a_n   (sel_a_n),
    .sel_b_n   (sel_b_n),
    .sel_c     (sel_c),
    .addr      (addr),
    .oe_n      (oe_n),
    .dout_en   (dout_en),
    .beat_act  (beat_act),
    .beat_wr   (beat_wr),
    .beat_addr (beat_addr),
    .burst_on  (burst_on)
);

// File: tb/tb_zbt_sram_core.sv
`timescale 1ns/1ps
module tb_zbt_sram_core;

    localparam logic [35:0] VA  = 36'h0A1B2C3D4;
    localparam logic [35:0] VB  = 36'h15A5A5A5A;
    localparam logic [35:0] VC  = 36'hFEDCBA987;
    localparam logic [35:0] W0  = 36'h111111111;
    localparam logic [35:0] W1  = 36'h222222222;
    localparam logic [35:0] W2  = 36'h333333333;
    localparam logic [35:0] W3  = 36'h444444444;
    localparam logic [35:0] X1  = 36'h9ABCDEF01;
    localparam logic [35:0] VD  = 36'h5C3A1E0F7;
    localparam logic [35:0] JNK = 36'hBADBADBAD;
    localparam logic [35:0] M02 = 36'h007FC01FF;   // lanes 0 and 2
    localparam logic [35:0] M3  = 36'hFF8000000;   // lane 3
    localparam logic [35:0] MRG5 = (VC & M02) | (VA & ~M02);
    localparam logic [35:0] MRGX = (X1 & M3) | (W0 & ~M3);
    localparam logic [2:0]  S   = 3'b001;          // {sel_a_n, sel_b_n, sel_c} selected

    typedef struct packed {
        logic        cen_n;
        logic        adv;
        logic        rw;
        logic [2:0]  sel;
        logic [3:0]  bw;
        logic [7:0]  a;
        logic [35:0] d;
        logic        oe;
        logic        xen;
        logic [35:0] xd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,S,     4'b0000,8'h10,36'h0,1'b0,1'b0,36'h0,4'd1},  // R1 write load
        '{1'b0,1'b0,1'b0,S,     4'b0000,8'h11,VA,   1'b0,1'b0,36'h0,4'd3},  // R3 data for 0x10
        '{1'b0,1'b0,1'b1,S,     4'b0000,8'h10,VB,   1'b0,1'b1,VA,   4'd2},  // R2 read 0x10
        '{1'b0,1'b0,1'b1,S,     4'b0101,8'h11,36'h0,1'b0,1'b1,VB,   4'd2},  // R2 bw ignored
        '{1'b0,1'b0,1'b0,S,     4'b1010,8'h10,36'h0,1'b0,1'b0,36'h0,4'd3},  // R3 partial write
        '{1'b0,1'b0,1'b1,S,     4'b1111,8'h10,VC,   1'b0,1'b1,MRG5, 4'd9},  // R9 read after write
        '{1'b0,1'b0,1'b0,S,     4'b0000,8'h21,36'h0,1'b0,1'b0,36'h0,4'd9},  // R9 write after read
        '{1'b0,1'b1,1'b1,S,     4'b0000,8'hFF,W0,   1'b0,1'b0,36'h0,4'd6},  // R6 rw ignored
        '{1'b0,1'b1,1'b0,S,     4'b0000,8'h00,W1,   1'b0,1'b0,36'h0,4'd4},  // R4
        '{1'b0,1'b1,1'b0,S,     4'b0000,8'h00,W2,   1'b0,1'b0,36'h0,4'd4},  // R4
        '{1'b0,1'b0,1'b1,S,     4'b1111,8'h21,W3,   1'b0,1'b1,W0,   4'd4},  // R4 beat 0x21
        '{1'b0,1'b1,1'b1,S,     4'b1111,8'h00,36'h0,1'b0,1'b1,W1,   4'd4},  // R4 beat 0x22
        '{1'b0,1'b1,1'b0,S,     4'b0000,8'h77,36'h0,1'b0,1'b1,W2,   4'd6},  // R6 stays read
        '{1'b0,1'b1,1'b1,S,     4'b1111,8'h00,36'h0,1'b0,1'b1,W3,   4'd4},  // R4 beat 0x20
        '{1'b0,1'b1,1'b1,S,     4'b1111,8'h00,36'h0,1'b0,1'b1,W0,   4'd4},  // R4 wrap 0x21
        '{1'b1,1'b0,1'b0,S,     4'b0000,8'h10,VC,   1'b0,1'b1,W0,   4'd8},  // R8 stalled edge
        '{1'b0,1'b0,1'b1,3'b011,4'b1111,8'h00,36'h0,1'b0,1'b0,36'h0,4'd7},  // R7 deselect
        '{1'b0,1'b1,1'b1,S,     4'b1111,8'h00,36'h0,1'b0,1'b0,36'h0,4'd7},  // R7 no burst
        '{1'b0,1'b0,1'b1,S,     4'b1111,8'h11,36'h0,1'b1,1'b0,36'h0,4'd10}, // R10 oe high
        '{1'b0,1'b0,1'b1,S,     4'b1111,8'h11,36'h0,1'b0,1'b1,VB,   4'd2},  // R2
        '{1'b0,1'b0,1'b1,3'b000,4'b1111,8'h00,36'h0,1'b0,1'b0,36'h0,4'd7}   // R7 sel_c low
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cen_n = 1'b0;
    logic        adv_ld = 1'b1;
    logic        rw = 1'b1;
    logic        sel_a_n = 1'b1;
    logic        sel_b_n = 1'b1;
    logic        sel_c = 1'b0;
    logic [7:0]  addr = '0;
    logic [3:0]  bw_n = '1;
    logic [35:0] din = '0;
    logic        burst_ilv = 1'b0;
    logic        oe_n = 1'b0;
    logic [35:0] dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    zbt_sram_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cen_n     (cen_n),
        .adv_ld    (adv_ld),
        .rw        (rw),
        .sel_a_n   (sel_a_n),
        .sel_b_n   (sel_b_n),
        .sel_c     (sel_c),
        .addr      (addr),
        .bw_n      (bw_n),
        .din       (din),
        .burst_ilv (burst_ilv),
        .oe_n      (oe_n),
        .dout      (dout),
        .dout_en   (dout_en)
    );

    task automatic check(input string tag, input logic xen, input logic [35:0] xd);
        checks++;
        if (dout_en !== xen || (xen && dout !== xd)) begin
            errors++;
            $display("FAIL %s: actual en=%0b dout=%h expected en=%0b dout=%h",
                     tag, dout_en, dout, xen, xd);
        end
    endtask

    // One cycle: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic cyc(input logic c, input logic adv, input logic r, input logic [2:0] sel,
                       input logic [3:0] bw, input logic [7:0] a, input logic [35:0] d,
                       input logic oe, input logic xen, input logic [35:0] xd, input string tag);
        @(negedge clk);
        cen_n = c; adv_ld = adv; rw = r;
        {sel_a_n, sel_b_n, sel_c} = sel;
        bw_n = bw; addr = a; din = d; oe_n = oe;
        @(posedge clk);
        #1;
        check(tag, xen, xd);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset", 1'b0, 36'h0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0,1'b1,1'b1,S,4'hF,8'h00,36'h0,1'b0,1'b0,36'h0,"R11 no burst after reset");

        foreach (TBL[i]) begin
            cyc(TBL[i].cen_n, TBL[i].adv, TBL[i].rw, TBL[i].sel, TBL[i].bw, TBL[i].a,
                TBL[i].d, TBL[i].oe, TBL[i].xen, TBL[i].xd,
                $sformatf("R%0d row %0d", TBL[i].req, i));
        end

        // R5: interleaved read burst from 0x22 -> 22, 23, 20, 21
        @(negedge clk);
        burst_ilv = 1'b1;
        cyc(1'b0,1'b0,1'b1,S,4'hF,8'h22,36'h0,1'b0,1'b1,W1,"R5 beat0");
        cyc(1'b0,1'b1,1'b1,S,4'hF,8'h00,36'h0,1'b0,1'b1,W2,"R5 beat1");
        cyc(1'b0,1'b1,1'b1,S,4'hF,8'h00,36'h0,1'b0,1'b1,W3,"R5 beat2");
        cyc(1'b0,1'b1,1'b1,S,4'hF,8'h00,36'h0,1'b0,1'b1,W0,"R5 beat3");
        cyc(1'b0,1'b0,1'b1,3'b101,4'hF,8'h00,36'h0,1'b0,1'b0,36'h0,"R7 deselect");
        @(negedge clk);
        burst_ilv = 1'b0;

        // R8: stall in the data cycle of a write
        cyc(1'b0,1'b0,1'b0,S,4'h0,8'h30,36'h0,1'b0,1'b0,36'h0,"R8 write load");
        cyc(1'b1,1'b0,1'b1,S,4'h0,8'h10,JNK,  1'b0,1'b0,36'h0,"R8 stalled data");
        cyc(1'b0,1'b0,1'b1,S,4'hF,8'h30,VD,   1'b0,1'b1,VD,  "R8 late data committed");
        cyc(1'b0,1'b0,1'b1,S,4'hF,8'h10,36'h0,1'b0,1'b1,MRG5,"R8 stalled write ignored");

        // R3 / R6: per-beat byte enables in a linear burst write from 0x20
        cyc(1'b0,1'b0,1'b0,S,4'b1111,8'h20,36'h0,1'b0,1'b0,36'h0,"R6 masked beat load");
        cyc(1'b0,1'b1,1'b1,S,4'b0111,8'h00,JNK,  1'b0,1'b0,36'h0,"R6 second beat");
        cyc(1'b0,1'b0,1'b1,S,4'hF,8'h21,X1,   1'b0,1'b1,MRGX,"R6 lane3 only");
        cyc(1'b0,1'b1,1'b1,S,4'hF,8'h00,36'h0,1'b0,1'b1,W1,  "R4 neighbour 0x22");
        cyc(1'b0,1'b0,1'b1,S,4'hF,8'h20,36'h0,1'b0,1'b1,W3,  "R3 masked beat kept");
        cyc(1'b0,1'b0,1'b1,S,4'hF,8'h20,36'h0,1'b1,1'b0,36'h0,"R10 oe high");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule